// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Retransmit

This block is a 9-bit-wide first-in first-out buffer. Writes happen on a write clock and reads on an independent read clock. The read behaviour is fixed when master reset is applied, and there are two choices. In standard mode, a read enable fetches a word into the output register on the next read-clock edge. In fall-through mode, the word at the head of the buffer moves into the output register without being asked for, and a read enable moves on to the next word.

Five status outputs come from pointer arithmetic in the clock domain that each one belongs to:
- an empty / not-ready indication on the read side;
- a full / not-ready indication on the write side;
- a more-than-half-full indication;
- an almost-empty indication whose threshold comes from an input;
- an almost-full indication whose threshold comes from an input.

A retransmit strobe sets the read pointer back to RAM location zero, so the stored data can be read again. Master reset clears everything and captures the mode. Partial reset empties the buffer but keeps the mode.

Pointers cross between the two clock domains as Gray code through two-stage synchronizers. Both clocks must run while a reset is held, because every reset is sampled synchronously in its own domain.

Top module: `dualmode_fifo`

## Requirements
- R1: On every write-clock edge with `mrs_n` low, the mode is captured from `mode_sel` (0 = standard, 1 = fall-through). Later changes of `mode_sel` have no effect. After one write in standard mode with no read, `dout` keeps its reset value.
- R2: In standard mode, a read enable accepted while `empty_nrdy` is low loads the oldest stored word onto `dout` at that read-clock edge. Words come out in write order.
- R3: In fall-through mode, `empty_nrdy` goes low in the same edge that the head word appears on `dout`, with no read enable. A read enable moves to the next word, and `dout` holds while there is no read enable.
- R4: `full_nrdy` is high exactly when the RAM holds DEPTH words. In fall-through mode that is DEPTH+1 words written and not yet taken, because the output register holds one word.
- R5: In standard mode, `empty_nrdy` is high exactly when the RAM holds no word. In fall-through mode, it is high exactly when the output register holds no valid word.
- R6: `half_full` is high when the RAM holds more than DEPTH/2 words. In fall-through mode, the word in the output register is not counted.
- R7: `almost_full` is high when the RAM holds at least DEPTH − `af_offset` words.
- R8: `almost_empty` is high when the RAM holds at most `ae_offset` words.
- R9: A write while `full_nrdy` is high leaves the stored data and write pointer unchanged. In standard mode, a read while `empty_nrdy` is high leaves `dout` unchanged.
- R10: `rt_n` low at a read-clock edge sets the read pointer to location 0 and leaves the write pointer unchanged. The data written since reset can then be read again. In fall-through mode, location 0 reappears on `dout` by itself.
- R11: After master reset, `dout` is 0, `empty_nrdy` and `almost_empty` are high, and `full_nrdy`, `half_full` and `almost_full` are low.
- R12: Partial reset (`prs_n` low) empties the buffer and keeps the captured mode. It does not clear `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low, sampled in both domains |
| prs_n | input | 1 | Partial reset, active low, sampled in both domains |
| mode_sel | input | 1 | Mode chosen while master reset is held (1 = fall-through) |
| wr_en | input | 1 | Write enable |
| din | input | DW | Write data |
| rd_en | input | 1 | Read enable |
| rt_n | input | 1 | Retransmit, active low, sampled on rclk |
| ae_offset | input | AW | Almost-empty threshold in words |
| af_offset | input | AW | Almost-full distance from DEPTH in words |
| dout | output | DW | Output register |
| empty_nrdy | output | 1 | Empty (standard) or output not ready (fall-through) |
| full_nrdy | output | 1 | Full, no write possible |
| half_full | output | 1 | More than half the RAM is occupied |
| almost_empty | output | 1 | Occupancy at or below `ae_offset` |
| almost_full | output | 1 | Occupancy at or above DEPTH − `af_offset` |

## Verification
The hardest state to reach is a fall-through retransmit after part of the data has been read. The output register must drop its current word and reload location 0, and the read pointer must jump while the synchronized write pointer stays where it is. The bench writes a short burst, reads part of it back, and pulses `rt_n`. It then rebuilds its expected queue from the full write history and checks that each word comes out again in order. Runs that fill the RAM completely in both modes, plus a write attempted while full, cover the wrap of the extra pointer bit and the DEPTH+1 capacity in fall-through mode.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FALL = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_gray_sync.sv
`timescale 1ns/1ps
module fifo_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (clr) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out = gray_to_bin(stage2);
endmodule

// File: rtl/fifo_ram.sv
`timescale 1ns/1ps
module fifo_ram #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/1ps
module fifo_wr_side #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wen,
  input  logic [PW-1:0] rd_bin_s,
  input  logic [AW-1:0] af_ofs,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] level,
  output logic          wr_go,
  output logic          full,
  output logic          almost_full,
  output logic          half_full
);
  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic reach_af(input logic [PW-1:0] lvl, input logic [AW-1:0] ofs);
    return lvl >= (PW'(DEPTH) - {1'b0, ofs});
  endfunction

  logic [PW-1:0] wptr_nx;

  assign level       = wptr - rd_bin_s;
  assign full        = (level == PW'(DEPTH));
  assign wr_go       = wen & ~full;
  assign almost_full = reach_af(level, af_ofs);
  assign half_full   = level > PW'(DEPTH / 2);
  assign wptr_nx     = wptr + 1'b1;

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (wr_go) begin
      wptr  <= wptr_nx;
      wgray <= bin_to_gray(wptr_nx);
    end
  end
endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/1ps
module fifo_rd_side
  import fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int PW    = 5,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          clr_data,
  input  rd_mode_e      mode,
  input  logic          ren,
  input  logic          rewind,
  input  logic [PW-1:0] wr_bin_s,
  input  logic [AW-1:0] ae_ofs,
  input  logic [DW-1:0] mem_q,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] dout,
  output logic          empty_flag,
  output logic          almost_empty
);
  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] level;
  logic          mem_empty;
  logic          out_valid;
  logic          rd_go;
  logic          fall;
  logic [PW-1:0] rptr_nx;

  assign fall         = (mode == MODE_FALL);
  assign level        = wr_bin_s - rptr;
  assign mem_empty    = (level == '0);
  assign almost_empty = level <= {1'b0, ae_ofs};
  assign rd_go        = ~rewind & ~mem_empty & (fall ? (~out_valid | ren) : ren);
  assign empty_flag   = fall ? ~out_valid : mem_empty;
  assign rptr_nx      = rptr + 1'b1;

  always_ff @(posedge clk) begin
    if (clr) begin
      rptr      <= '0;
      rgray     <= '0;
      out_valid <= 1'b0;
    end else if (rewind) begin
      rptr      <= '0;
      rgray     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (rd_go) begin
        rptr  <= rptr_nx;
        rgray <= bin_to_gray(rptr_nx);
      end
      if (rd_go)    out_valid <= fall;
      else if (ren) out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_data)   dout <= '0;
    else if (rd_go) dout <= mem_q;
  end
endmodule

// File: rtl/dualmode_fifo.sv
`timescale 1ns/1ps
module dualmode_fifo
  import fifo_pkg::*;
#(
  parameter  int DEPTH = 2048,
  parameter  int DW    = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrs_n,
  input  logic          prs_n,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  input  logic          rt_n,
  input  logic [AW-1:0] ae_offset,
  input  logic [AW-1:0] af_offset,
  output logic [DW-1:0] dout,
  output logic          empty_nrdy,
  output logic          full_nrdy,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int PW = AW + 1;

  rd_mode_e      mode_q;
  logic          clr_any;
  logic          clr_master;
  logic [PW-1:0] wr_ptr, wr_gray, wr_level, wr_bin_s;
  logic [PW-1:0] rd_ptr, rd_gray, rd_bin_s;
  logic          wr_go;
  logic [DW-1:0] mem_q;

  assign clr_any    = ~mrs_n | ~prs_n;
  assign clr_master = ~mrs_n;

  always_ff @(posedge wclk) begin
    if (clr_master) mode_q <= mode_sel ? MODE_FALL : MODE_STD;
  end

  fifo_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wclk), .clr(clr_any), .wen(wr_en), .rd_bin_s(rd_bin_s), .af_ofs(af_offset),
    .wptr(wr_ptr), .wgray(wr_gray), .level(wr_level), .wr_go(wr_go),
    .full(full_nrdy), .almost_full(almost_full), .half_full(half_full)
  );

  fifo_gray_sync #(.W(PW)) u_r2w (
    .clk(wclk), .clr(clr_any), .gray_in(rd_gray), .bin_out(rd_bin_s)
  );

  fifo_gray_sync #(.W(PW)) u_w2r (
    .clk(rclk), .clr(clr_any), .gray_in(wr_gray), .bin_out(wr_bin_s)
  );

  fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_go), .waddr(wr_ptr[AW-1:0]), .wdata(din),
    .raddr(rd_ptr[AW-1:0]), .rdata(mem_q)
  );

  fifo_rd_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .DW(DW)) u_rd (
    .clk(rclk), .clr(clr_any), .clr_data(clr_master), .mode(mode_q), .ren(rd_en),
    .rewind(~rt_n), .wr_bin_s(wr_bin_s), .ae_ofs(ae_offset), .mem_q(mem_q),
    .rptr(rd_ptr), .rgray(rd_gray), .dout(dout), .empty_flag(empty_nrdy),
    .almost_empty(almost_empty)
  );
endmodule

// File: rtl/dualmode_fifo_chk.sv
`timescale 1ns/1ps
module dualmode_fifo_chk
  import fifo_pkg::*;
#(
  parameter  int DEPTH = 2048,
  parameter  int DW    = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrs_n,
  input logic          prs_n,
  input logic          rt_n,
  input logic          rd_en,
  input logic          full_nrdy,
  input logic          half_full,
  input logic          almost_full,
  input logic          empty_nrdy,
  input logic [DW-1:0] dout,
  input rd_mode_e      mode_q,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_level
);
  // R1
  mode_hold_chk: assert property (@(posedge wclk) disable iff (!mrs_n)
    mrs_n |=> $stable(mode_q));

  // R4
  level_cap_chk: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
    wr_level <= PW'(DEPTH));

  // R9
  no_write_when_full_chk: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
    full_nrdy |=> $stable(wr_ptr));

  // R6
  half_with_full_chk: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
    full_nrdy |-> half_full);

  // R7
  afull_with_full_chk: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
    full_nrdy |-> almost_full);

  // R10
  rewind_zero_chk: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
    !rt_n |=> (rd_ptr == '0));

  // R9
  idle_read_hold_chk: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
    (mode_q == MODE_STD && empty_nrdy && rt_n) |=> $stable(dout));

  // R3
  fall_hold_chk: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
    (mode_q == MODE_FALL && !empty_nrdy && !rd_en && rt_n) |=> (!empty_nrdy && $stable(dout)));
endmodule

bind dualmode_fifo dualmode_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/tb_dualmode_fifo.sv
`timescale 1ns/1ps
module tb_dualmode_fifo;
  localparam int DEPTH = 16;
  localparam int DW    = 9;
  localparam int AW    = 4;
  localparam int AE    = 2;
  localparam int AF    = 3;

  logic wclk = 0, rclk = 0;
  always #2   wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  logic mrs_n = 0, prs_n = 1, mode_sel = 0, wr_en = 0, rd_en = 0, rt_n = 1;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] ae_offset = AW'(AE), af_offset = AW'(AF);
  logic [DW-1:0] dout;
  logic empty_nrdy, full_nrdy, half_full, almost_empty, almost_full;

  dualmode_fifo #(.DEPTH(DEPTH), .DW(DW)) dut (.*);

  int total = 0, bad = 0;
  int q[$];
  int hist[$];
  bit fall = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
  endtask

  task automatic flags();
    int n = q.size();
    int m = (fall && n > 0) ? n - 1 : n;
    chk(full_nrdy == (m == DEPTH), "R4 full", full_nrdy, m == DEPTH);
    chk(half_full == (m > DEPTH / 2), "R6 half", half_full, m > DEPTH / 2);
    chk(almost_full == (m >= DEPTH - AF), "R7 almost_full", almost_full, m >= DEPTH - AF);
    chk(almost_empty == (m <= AE), "R8 almost_empty", almost_empty, m <= AE);
    chk(empty_nrdy == (n == 0), "R5 empty", empty_nrdy, n == 0);
  endtask

  task automatic mreset(bit m);
    wr_en = 0; rd_en = 0; rt_n = 1; mode_sel = m; mrs_n = 0;
    repeat (3) @(negedge rclk);
    mrs_n = 1; mode_sel = ~m; fall = m;
    q.delete(); hist.delete();
    @(negedge rclk);
  endtask

  task automatic preset();
    prs_n = 0;
    repeat (3) @(negedge rclk);
    prs_n = 1;
    q.delete(); hist.delete();
    @(negedge rclk);
  endtask

  task automatic write_n(int n, int seed);
    int done = 0;
    while (done < n) begin
      @(negedge wclk);
      if (!full_nrdy) begin
        int v = ((seed + done * 37) % 511) + 1;
        wr_en = 1; din = DW'(v);
        q.push_back(v); hist.push_back(v);
        done++;
      end else wr_en = 0;
    end
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic read_n(int n);
    int cnt = 0;
    int exp = 0;
    bit pend = 0;
    forever begin
      @(negedge rclk);
      if (pend) chk(dout == DW'(exp), "R2 read data", dout, exp);
      pend = 0;
      if (cnt == n) begin rd_en = 0; break; end
      if (!empty_nrdy) begin
        if (q.size() == 0) begin
          chk(0, "R5 flag says data but none written", 1, 0);
          rd_en = 0; break;
        end
        if (fall) chk(dout == DW'(q[0]), "R3 head word", dout, q[0]);
        rd_en = 1; exp = q.pop_front(); cnt++;
        if (!fall) pend = 1;
      end else rd_en = 0;
    end
  endtask

  task automatic retransmit();
    @(negedge rclk); rt_n = 0;
    @(negedge rclk); rt_n = 1;
    q = hist;
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] last;
    // R11 reset state in standard mode
    mreset(0);
    chk(dout == 0, "R11 dout cleared", dout, 0);
    chk(empty_nrdy == 1 && almost_empty == 1, "R11 empty side", {empty_nrdy, almost_empty}, 3);
    chk(full_nrdy == 0 && half_full == 0 && almost_full == 0, "R11 full side",
        {full_nrdy, half_full, almost_full}, 0);
    // R1 standard mode: no fall-through
    write_n(1, 5); settle();
    chk(dout == 0, "R1 standard holds dout", dout, 0);
    flags();
    read_n(1); settle(); flags();
    // R2 R5 R8 basic burst
    write_n(5, 40); settle(); flags();
    read_n(5); settle(); flags();
    // R6 R7 R4 thresholds
    write_n(9, 100); settle(); flags();
    write_n(3, 200); settle(); flags();
    write_n(1, 300); settle(); flags();
    write_n(3, 400); settle(); flags();
    // R9 write while full
    @(negedge wclk); wr_en = 1; din = 9'h1AA;
    @(negedge wclk); wr_en = 0;
    settle(); flags();
    read_n(16); settle(); flags();
    // R9 read while empty
    last = dout; rd_en = 1;
    repeat (3) begin
      @(negedge rclk);
      chk(dout == last, "R9 read while empty", dout, last);
    end
    rd_en = 0;
    chk(empty_nrdy == 1, "R9 still empty", empty_nrdy, 1);

    // R10 standard retransmit
    mreset(0);
    write_n(6, 7); settle();
    read_n(3);
    retransmit(); settle(); flags();
    read_n(6); settle(); flags();

    // R3 R4 fall-through
    mreset(1);
    write_n(1, 77); settle();
    chk(empty_nrdy == 0, "R3 ready without read", empty_nrdy, 0);
    chk(dout == DW'(q[0]), "R3 word falls through", dout, q[0]);
    flags();
    write_n(16, 90); settle(); flags();
    read_n(17); settle(); flags();

    // R10 fall-through retransmit
    mreset(1);
    write_n(5, 250); settle();
    read_n(2);
    retransmit(); settle();
    chk(dout == DW'(hist[0]), "R10 first word reappears", dout, hist[0]);
    flags();
    read_n(5); settle(); flags();

    // R12 partial reset in fall-through keeps the mode
    write_n(4, 333); settle();
    preset();
    chk(empty_nrdy == 1, "R12 empty after partial reset", empty_nrdy, 1);
    write_n(1, 12); settle();
    chk(dout == DW'(q[0]), "R12 mode kept (fall-through)", dout, q[0]);
    read_n(1); settle(); flags();

    // R12 partial reset in standard mode keeps dout and mode
    mreset(0);
    write_n(3, 60); settle();
    read_n(1); last = dout;
    preset(); settle();
    chk(dout == last, "R12 dout kept", dout, last);
    flags();
    write_n(1, 21); settle();
    chk(dout == last, "R12 mode kept (standard)", dout, last);
    read_n(1); settle(); flags();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule